// File: doc/BRIEF.md
# Versioned Memory-Controller Register Bank

This block is the software-visible register file of an error-correcting DRAM controller. It has seven 32-bit registers on a simple synchronous word-addressed bus and one level interrupt. The actual memory control, refresh sequencing and error detection live elsewhere. A fault-inject port stands in for the error detector: a pulse loads a fault word and raises the interrupt, and software clears the interrupt by writing the fault status register.

The build-time parameter `VARIANT` (0, 1 or 2) selects one of three controller generations. The variant changes how the enable register behaves. It sets which bits a write stores, which bits survive a reset, and whether a read-only identity code appears in the top byte. Only the variant-0 build contains a 16-byte diagnostic scratch memory, reached through its own byte-wide port.

Reset is synchronous and active low. Some registers keep part or all of their contents through reset by design.

Top module: `memctl_regbank`

## Requirements
- R1: The enable register (index 0) carries the identity code `VARIANT << 28` in bits 31:24, with implementation in 31:28 and version in 27:24. For variants 1 and 2 these bits always read back as that code and ignore written data. For variant 0 they read zero.
- R2: A write to index 0 stores `wdata & 0x00000103` for variant 0. For variants 1 and 2 it stores `identity | (wdata & 0x00000bff)`.
- R3: Reset makes the enable register `old & 0x00000100` for variant 0. For variants 1 and 2 it becomes `old & 0xff000bfc`.
- R4: Before any reset has been applied, the enable register reads the identity code.
- R5: The bus address is the register index: 0 enable, 1 delay, 2 fault status, 3 video configuration, 4 diagnostic, 5 error control 0, 6 error control 1. Indices 1 and 3 to 6 store all 32 written bits. Reads return the value combinationally in the cycle of the request.
- R6: Reset loads 0x20 into the delay register and zero into fault status, video configuration and error control 1. The diagnostic register and error control 0 keep their contents.
- R7: A one-cycle `fault_inject` pulse loads `fault_word` into fault status and sets `irq` on the next edge. `irq` then stays high until fault status is written or reset is applied.
- R8: A bus write to index 2 stores the data and clears `irq` on the next edge. If an inject happens in the same cycle, the inject wins for both the stored value and `irq`.
- R9: Reads of indices 7 and above return zero. Writes to them change no register.
- R10: In the variant-0 build, a diagnostic write stores one byte at `diag_addr`. A diagnostic read returns the byte on `diag_rdata` one cycle after the request.
- R11: In variants 1 and 2 the diagnostic memory is absent. `diag_rdata` is always zero and diagnostic writes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Register index (word address) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed index |
| fault_inject | input | 1 | Test pulse that loads fault status |
| fault_word | input | 32 | Value loaded on inject |
| irq | output | 1 | Level interrupt |
| diag_req | input | 1 | Diagnostic memory request |
| diag_we | input | 1 | Diagnostic write enable |
| diag_addr | input | DIAG_AW (4) | Diagnostic byte address |
| diag_wdata | input | 8 | Diagnostic write byte |
| diag_rdata | output | 8 | Diagnostic read byte, one cycle latency |

## Verification
The hardest behaviour to reach is the enable register's retention across reset. Its value after reset depends on what was written before. An inject and a fault-status write in the same cycle are also hard to reach. The bench drives a variant-0 and a variant-2 instance from the same stimulus. Random enable writes, resets and injects are interleaved so that reset lands on many different enable values. A directed step places the inject and the fault-status write in one cycle. Another checks the enable value in the cycles before the first reset.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int NREGS = 7;
  localparam logic [31:0] EN_WMASK_V0  = 32'h0000_0103;
  localparam logic [31:0] EN_WMASK_V12 = 32'h0000_0bff;
  localparam logic [31:0] EN_KEEP_V0   = 32'h0000_0100;
  localparam logic [31:0] EN_KEEP_V12  = 32'hff00_0bfc;
  localparam logic [31:0] DELAY_RST    = 32'h0000_0020;

  typedef enum logic [2:0] {
    IX_ENABLE = 3'd0, IX_DELAY = 3'd1, IX_FAULT = 3'd2, IX_VIDEO = 3'd3,
    IX_DIAG   = 3'd4, IX_ERR0  = 3'd5, IX_ERR1  = 3'd6
  } reg_ix_e;

  function automatic logic [31:0] variant_ident(int v);
    return 32'(v) << 28;
  endfunction

  function automatic logic [31:0] enable_on_write(int v, logic [31:0] d);
    if (v == 0) return d & EN_WMASK_V0;
    return variant_ident(v) | (d & EN_WMASK_V12);
  endfunction

  function automatic logic [31:0] enable_on_reset(int v, logic [31:0] cur);
    if (v == 0) return cur & EN_KEEP_V0;
    return cur & EN_KEEP_V12;
  endfunction

  function automatic logic [31:0] enable_legal_bits(int v);
    if (v == 0) return EN_WMASK_V0;
    return 32'hff00_0000 | EN_WMASK_V12;
  endfunction
endpackage

// File: rtl/mcr_enable_reg.sv
module mcr_enable_reg
  import mcr_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  localparam logic [31:0] IDENT = variant_ident(VARIANT);

  logic [31:0] q_r = IDENT;

  always_ff @(posedge clk) begin
    if (!rst_n)   q_r <= enable_on_reset(VARIANT, q_r);
    else if (wr)  q_r <= enable_on_write(VARIANT, wdata);
  end

  assign q = q_r;

  assert_ident_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
    q_r[31:24] == IDENT[31:24] || (VARIANT == 0 && q_r[31:24] == 8'h00));

  assert_write_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q_r & ~enable_legal_bits(VARIANT)) == 32'h0);

  assert_reset_keep_R3: assert property (@(posedge clk)
    !rst_n |=> (q_r & ~(VARIANT == 0 ? EN_KEEP_V0 : EN_KEEP_V12)) == 32'h0);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && rst_n) |=> $stable(q_r) || !rst_n);
endmodule

// File: rtl/mcr_plain_reg.sv
module mcr_plain_reg #(
  parameter logic [31:0] RST_VAL = 32'h0,
  parameter bit          RETAIN  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  logic [31:0] q_r = 32'h0;

  generate
    if (RETAIN) begin : g_keep
      always_ff @(posedge clk) begin
        if (rst_n && wr) q_r <= wdata;
      end
    end else begin : g_clr
      always_ff @(posedge clk) begin
        if (!rst_n)   q_r <= RST_VAL;
        else if (wr)  q_r <= wdata;
      end
    end
  endgenerate

  assign q = q_r;

  assert_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q_r == $past(wdata)) || !rst_n);
endmodule

// File: rtl/mcr_fault_irq.sv
module mcr_fault_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_wr,
  input  logic [31:0] sw_wdata,
  input  logic        inj,
  input  logic [31:0] inj_word,
  output logic [31:0] status,
  output logic        irq
);
  logic [31:0] status_r = 32'h0;
  logic        irq_r    = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_r <= 32'h0;
      irq_r    <= 1'b0;
    end else if (inj) begin
      status_r <= inj_word;
      irq_r    <= 1'b1;
    end else if (sw_wr) begin
      status_r <= sw_wdata;
      irq_r    <= 1'b0;
    end
  end

  assign status = status_r;
  assign irq    = irq_r;

  assert_inject_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inj |=> (irq_r && status_r == $past(inj_word)) || !rst_n);

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj && !sw_wr && irq_r) |=> irq_r || !rst_n);

  assert_sw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !inj) |=> !irq_r);

  assert_reset_quiet_R6: assert property (@(posedge clk)
    !rst_n |=> (!irq_r && status_r == 32'h0));
endmodule

// File: rtl/mcr_diag_ram.sv
module mcr_diag_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];
  logic [7:0] rd_r = 8'h0;
  logic       rd_fire;

  assign rd_fire = req && !we;

  always_ff @(posedge clk) begin
    if (req && we) mem[addr] <= wdata;
    if (rd_fire)   rd_r <= mem[addr];
  end

  assign rdata = rd_r;

  assert_read_hold_R10: assert property (@(posedge clk)
    !rd_fire |=> $stable(rd_r));
endmodule

// File: rtl/memctl_regbank.sv
module memctl_regbank
  import mcr_pkg::*;
#(
  parameter int VARIANT    = 0,
  parameter int ADDR_W     = 4,
  parameter int DIAG_DEPTH = 16,
  parameter int DIAG_AW    = $clog2(DIAG_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               fault_inject,
  input  logic [31:0]        fault_word,
  output logic               irq,
  input  logic               diag_req,
  input  logic               diag_we,
  input  logic [DIAG_AW-1:0] diag_addr,
  input  logic [7:0]         diag_wdata,
  output logic [7:0]         diag_rdata
);
  localparam int IXW   = $clog2(NREGS);
  localparam int SLOTS = 2 ** IXW;

  logic [NREGS-1:0] wr_hit;
  logic [31:0]      regq [SLOTS];
  logic             in_range;
  logic [IXW-1:0]   ix;

  assign in_range = bus_addr < ADDR_W'(NREGS);
  assign ix       = bus_addr[IXW-1:0];

  generate
    for (genvar i = 0; i < NREGS; i++) begin : g_dec
      assign wr_hit[i] = bus_sel && bus_we && (bus_addr == ADDR_W'(i));
    end
    for (genvar i = NREGS; i < SLOTS; i++) begin : g_pad
      assign regq[i] = 32'h0;
    end
  endgenerate

  mcr_enable_reg #(.VARIANT(VARIANT)) u_enable (
    .clk(clk), .rst_n(rst_n), .wr(wr_hit[IX_ENABLE]),
    .wdata(bus_wdata), .q(regq[IX_ENABLE])
  );

  mcr_fault_irq u_fault (
    .clk(clk), .rst_n(rst_n), .sw_wr(wr_hit[IX_FAULT]), .sw_wdata(bus_wdata),
    .inj(fault_inject), .inj_word(fault_word),
    .status(regq[IX_FAULT]), .irq(irq)
  );

  generate
    for (genvar i = 1; i < NREGS; i++) begin : g_plain
      if (i != int'(IX_FAULT)) begin : g_reg
        mcr_plain_reg #(
          .RST_VAL(i == int'(IX_DELAY) ? DELAY_RST : 32'h0),
          .RETAIN (i == int'(IX_DIAG) || i == int'(IX_ERR0))
        ) u_reg (
          .clk(clk), .rst_n(rst_n), .wr(wr_hit[i]),
          .wdata(bus_wdata), .q(regq[i])
        );
      end
    end
  endgenerate

  assign bus_rdata = in_range ? regq[ix] : 32'h0;

  generate
    if (VARIANT == 0) begin : g_diag
      mcr_diag_ram #(.DEPTH(DIAG_DEPTH), .AW(DIAG_AW)) u_diag (
        .clk(clk), .req(diag_req), .we(diag_we), .addr(diag_addr),
        .wdata(diag_wdata), .rdata(diag_rdata)
      );
    end else begin : g_nodiag
      logic diag_unused;
      assign diag_unused = ^{diag_req, diag_we, diag_addr, diag_wdata};
      assign diag_rdata  = 8'h0;
    end
  endgenerate

  assert_decode_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !in_range) |-> bus_rdata == 32'h0);

  assert_no_diag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    VARIANT != 0 |-> diag_rdata == 8'h0);

  assert_delay_reset_R6: assert property (@(posedge clk)
    !rst_n |=> regq[IX_DELAY] == DELAY_RST);
endmodule

// File: tb/sim_memctl_regbank.sv
`timescale 1ns/1ps
module sim_memctl_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic        fault_inject = 1'b0;
  logic [31:0] fault_word = 32'h0;
  logic        diag_req = 1'b0, diag_we = 1'b0;
  logic [3:0]  diag_addr = 4'h0;
  logic [7:0]  diag_wdata = 8'h0;
  logic [31:0] rd0, rd1;
  logic        irq0, irq1;
  logic [7:0]  drd0, drd1;

  int total = 0;
  int bad   = 0;

  logic [31:0] mdl [2][7];
  bit          irq_m [2];
  logic [7:0]  dmem [16];

  always #4 clk = ~clk;

  memctl_regbank #(.VARIANT(0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd0),
    .fault_inject(fault_inject), .fault_word(fault_word), .irq(irq0),
    .diag_req(diag_req), .diag_we(diag_we), .diag_addr(diag_addr),
    .diag_wdata(diag_wdata), .diag_rdata(drd0));

  memctl_regbank #(.VARIANT(2)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd1),
    .fault_inject(fault_inject), .fault_word(fault_word), .irq(irq1),
    .diag_req(diag_req), .diag_we(diag_we), .diag_addr(diag_addr),
    .diag_wdata(diag_wdata), .diag_rdata(drd1));

  function automatic int var_of(int k);
    return (k == 0) ? 0 : 2;
  endfunction

  function automatic logic [31:0] exp_en_write(int v, logic [31:0] d);
    if (v == 0) return {23'h0, d[8], 6'h0, d[1:0]};
    return {4'(v), 16'h0, d[11:0]} & 32'hf000_0bff;
  endfunction

  function automatic logic [31:0] exp_en_reset(int v, logic [31:0] cur);
    if (v == 0) return {23'h0, cur[8], 8'h0};
    return {cur[31:24], 12'h0, cur[11], 1'b0, cur[9:2], 2'b00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_check(int idx, string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'(idx);
    #1;
    for (int k = 0; k < 2; k++)
      chk(req, (k == 0) ? rd0 : rd1, (idx < 7) ? mdl[k][idx] : 32'h0);
    bus_sel = 1'b0;
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'(idx); bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
    for (int k = 0; k < 2; k++) begin
      if (idx == 0) mdl[k][0] = exp_en_write(var_of(k), d);
      else if (idx == 2) begin mdl[k][2] = d; irq_m[k] = 1'b0; end
      else if (idx < 7) mdl[k][idx] = d;
    end
  endtask

  task automatic inject(logic [31:0] d);
    @(negedge clk);
    fault_inject = 1'b1; fault_word = d;
    @(posedge clk); #1;
    fault_inject = 1'b0;
    for (int k = 0; k < 2; k++) begin mdl[k][2] = d; irq_m[k] = 1'b1; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      mdl[k][0] = exp_en_reset(var_of(k), mdl[k][0]);
      mdl[k][1] = 32'h20;
      mdl[k][2] = 32'h0;
      mdl[k][3] = 32'h0;
      mdl[k][6] = 32'h0;
      irq_m[k] = 1'b0;
    end
  endtask

  task automatic irq_check(string req);
    #1;
    chk(req, {31'h0, irq0}, {31'h0, irq_m[0]});
    chk(req, {31'h0, irq1}, {31'h0, irq_m[1]});
  endtask

  task automatic diag_wr(int a, logic [7:0] d);
    @(negedge clk);
    diag_req = 1'b1; diag_we = 1'b1; diag_addr = 4'(a); diag_wdata = d;
    @(posedge clk); #1;
    diag_req = 1'b0; diag_we = 1'b0;
    dmem[a] = d;
  endtask

  task automatic diag_rd(int a);
    @(negedge clk);
    diag_req = 1'b1; diag_we = 1'b0; diag_addr = 4'(a);
    @(posedge clk); #1;
    diag_req = 1'b0;
    chk("R10 diag byte", {24'h0, drd0}, {24'h0, dmem[a]});
    chk("R11 no diag", {24'h0, drd1}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 7; i++) mdl[k][i] = 32'h0;
      mdl[k][0] = 32'(var_of(k)) << 28;
      irq_m[k] = 1'b0;
    end
    // R4: identity before the first reset
    rd_check(0, "R4 pre-reset enable");
    irq_check("R7 idle irq");

    // R1/R2: identity bits ignore writes, per-variant mask
    wr(0, 32'hffff_ffff);
    rd_check(0, "R1 R2 enable all ones");
    wr(0, 32'h0000_0000);
    rd_check(0, "R1 identity after zero write");

    // R5: full-width plain registers
    for (int i = 1; i < 7; i++) wr(i, 32'hA5A5_0000 | 32'(i));
    for (int i = 1; i < 7; i++) rd_check(i, "R5 plain rw");
    wr(0, 32'h0000_0bfd);

    // R3 R6: reset retention and reset values
    do_reset();
    for (int i = 0; i < 7; i++) rd_check(i, "R3 R6 after reset");
    irq_check("R6 irq after reset");

    // R7 R8: inject, sticky, clear
    inject(32'hDEAD_BEEF);
    irq_check("R7 inject raise");
    rd_check(2, "R7 inject value");
    repeat (3) @(negedge clk);
    irq_check("R7 irq sticky");
    wr(2, 32'h1234_5678);
    irq_check("R8 sw clear");
    rd_check(2, "R8 sw value");

    // R8: same-cycle inject and write, inject wins
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h0000_1111;
    fault_inject = 1'b1; fault_word = 32'hCAFE_0002;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0; fault_inject = 1'b0;
    for (int k = 0; k < 2; k++) begin mdl[k][2] = 32'hCAFE_0002; irq_m[k] = 1'b1; end
    irq_check("R8 collision irq");
    rd_check(2, "R8 collision value");

    // R9: unmapped indices
    wr(9, 32'hFFFF_FFFF);
    wr(15, 32'h0BAD_F00D);
    for (int i = 0; i < 7; i++) rd_check(i, "R9 writes ignored");
    rd_check(7, "R9 read zero");
    rd_check(12, "R9 read zero");

    // R10 R11: diagnostic memory
    for (int a = 0; a < 16; a++) diag_wr(a, 8'(a * 17 + 3));
    for (int a = 0; a < 16; a++) diag_rd(a);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0, 1: wr(int'($urandom % 10), $urandom);
        2:    wr(0, $urandom);
        3:    rd_check(int'($urandom % 10), "R5 R9 random read");
        4:    begin inject($urandom); irq_check("R7 random inject"); end
        5:    begin do_reset(); rd_check(0, "R3 random reset"); rd_check(4, "R6 keep diag reg"); end
        6:    diag_wr(int'($urandom % 16), 8'($urandom));
        default: begin diag_rd(int'($urandom % 16)); irq_check("R7 R8 random irq"); end
      endcase
    end
    for (int i = 0; i < 10; i++) rd_check(i, "R5 final sweep");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule